// File: doc/BRIEF.md
# Branch Trace Buffer with Loop Compression

This block keeps a short history of program-flow changes for debug. Whenever the core takes a branch it presents a source address, a destination address, a flag marking branches that come from hardware loops, and its current priority level. Events that pass the filters are pushed into a 16-entry circular store. A branch that repeats the newest recorded pair, or the pair before it, is not stored again. Instead, bit 0 of one of the stored addresses is set as a "seen again" marker.

Software reaches the buffer through a small register port with three registers:
- a control word (read/write);
- a count of valid entries;
- a data window that yields the newest entry one word at a time: destination first, then source.

The entry is removed on the second of those two reads, so reads come out newest first. When the store is full, the block either pulses an overflow exception request and drops the event, or silently replaces the oldest entry. Which one it does depends on a control bit.

Top module: `branch_trace_buf`

## Requirements
- R1: The store holds up to 16 entries; a read of address 0x004 returns the number of valid entries (0 to 16) in bits 4:0, zero above.
- R2: An event is recorded only when control bit 0 (power) and control bit 1 (enable) are both 1.
- R3: An event with `ev_hwloop` = 1, or with `ev_level` = 1 (the reset level), is never recorded.
- R4: When control bit 2 (overflow-exception mode) is 1, events at levels 0 to 3 are dropped; events at level 4 or above are handled normally.
- R5: If the store is full and bit 2 is 1, an accepted event is discarded and `ovf_exc` is high for exactly one cycle, in the cycle after the event.
- R6: If the store is full and bit 2 is 0, the oldest entry is lost and the new event is stored; `ovf_exc` stays low.
- R7: If control bits 4:3 are nonzero, and an event's source and destination equal the newest entry's addresses with their bit 0 taken as 0, nothing is stored. Instead, bit 0 of the newest entry's destination becomes 1.
- R8: If control bit 4 is 1, an event that fails the R7 test but matches the second-newest entry in the same way is not stored, and bit 0 of that entry's source becomes 1. The R7 test is applied first.
- R9: Address 0x000 reads back the 5 control bits written there; writes to any other address change nothing.
- R10: A read of address 0x100 returns 0 when the store is empty. Otherwise it returns the newest destination, and the next such read returns its source and removes the entry.
- R11: Read data appears on `reg_rdata` in the cycle after `reg_rd`. It shows the state before that cycle's updates.
- R12: An event in the same cycle as an entry-removing read is processed against the store after the removal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Branch event present this cycle |
| ev_src | input | 32 | Branch source address |
| ev_dst | input | 32 | Branch target address |
| ev_hwloop | input | 1 | Branch caused by a hardware loop |
| ev_level | input | 4 | Current core priority level |
| reg_addr | input | 9 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| ovf_exc | output | 1 | One-cycle overflow exception request |

## Verification
A corrupted count or write pointer shows on the next status read. It also shows on the next pair of data reads, as a wrong or reordered address. A stuck half-read toggle swaps destination and source within one read pair. Wrong compression or overflow decisions appear as an extra or missing entry in the count read right after the event. They can also show as a missing bit-0 marker in the drained data, or as an `ovf_exc` pulse one cycle after the offending event. The bench drains every entry it fills, so a fault in ordering or in eviction of the oldest entry surfaces within that same drain.

// File: rtl/branch_trace_buf.sv
module branch_trace_buf #(
  parameter int DEPTH = 16,
  parameter int AW = 9,
  parameter logic [AW-1:0] CTRL_A = 9'h000,
  parameter logic [AW-1:0] STAT_A = 9'h004,
  parameter logic [AW-1:0] DATA_A = 9'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic [31:0]   ev_src,
  input  logic [31:0]   ev_dst,
  input  logic          ev_hwloop,
  input  logic [3:0]    ev_level,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          ovf_exc
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = IW + 1;

  logic [4:0]    ctrl;
  logic [31:0]   src_m [DEPTH];
  logic [31:0]   dst_m [DEPTH];
  logic [IW-1:0] top;
  logic [CW-1:0] cnt;
  logic          second;
  logic [31:0]   rd_val;

  wire rd_data = reg_rd && reg_addr == DATA_A && cnt != '0;
  wire pop     = rd_data && second;

  wire [IW-1:0] top_p = top - IW'(pop);
  wire [CW-1:0] cnt_p = cnt - CW'(pop);
  wire [IW-1:0] n1    = top_p - IW'(1);
  wire [IW-1:0] n2    = top_p - IW'(2);
  wire [IW-1:0] head  = top - IW'(1);

  wire accept = ev_valid && ctrl[0] && ctrl[1] && !ev_hwloop && ev_level != 4'd1
                && !(ev_level <= 4'd3 && ctrl[2]);
  wire full   = cnt_p == CW'(DEPTH);
  wire ovf    = accept && full && ctrl[2];

  wire hit1 = ctrl[4:3] != 2'b00 && cnt_p >= CW'(1)
              && ev_src == {src_m[n1][31:1], 1'b0} && ev_dst == {dst_m[n1][31:1], 1'b0};
  wire hit2 = ctrl[4] && cnt_p >= CW'(2)
              && ev_src == {src_m[n2][31:1], 1'b0} && ev_dst == {dst_m[n2][31:1], 1'b0};

  wire comp1 = accept && !ovf && hit1;
  wire comp2 = accept && !ovf && !hit1 && hit2;
  wire push  = accept && !ovf && !hit1 && !hit2;

  always_comb begin
    case (reg_addr)
      CTRL_A:  rd_val = {27'd0, ctrl};
      STAT_A:  rd_val = 32'(cnt);
      DATA_A:  rd_val = (cnt == '0) ? 32'd0 : (second ? src_m[head] : dst_m[head]);
      default: rd_val = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      top       <= '0;
      cnt       <= '0;
      second    <= 1'b0;
      reg_rdata <= '0;
      ovf_exc   <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == CTRL_A) ctrl <= reg_wdata[4:0];
      if (reg_rd) reg_rdata <= rd_val;
      if (rd_data) second <= !second;
      ovf_exc <= ovf;
      top <= push ? top_p + IW'(1) : top_p;
      cnt <= (push && !full) ? cnt_p + CW'(1) : cnt_p;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      src_m[top_p] <= ev_src;
      dst_m[top_p] <= ev_dst;
    end
    if (comp1) dst_m[n1][0] <= 1'b1;
    if (comp2) src_m[n2][0] <= 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R1
  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!(ctrl[0] && ctrl[1]) && !pop) |=> cnt == $past(cnt) && top == $past(top)); // R2
  AST_HWLOOP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (ev_hwloop && !pop) |=> cnt == $past(cnt) && top == $past(top)); // R3
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) ovf_exc |-> $past(ev_valid && ctrl[2] && ev_level > 4'd3)); // R5
  AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n) ovf_exc |-> cnt >= CW'(DEPTH - 1)); // R5
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(reg_wr && reg_addr == CTRL_A) |=> $stable(ctrl)); // R9
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n) (reg_rd && reg_addr == DATA_A && cnt == '0) |=> reg_rdata == 32'd0); // R10
endmodule

// File: tb/test_branch_trace_buf.sv
module test_branch_trace_buf;
  logic        clk = 0, rst_n = 0;
  logic        ev_valid = 0, ev_hwloop = 0;
  logic [31:0] ev_src = 0, ev_dst = 0;
  logic [3:0]  ev_level = 0;
  logic [8:0]  reg_addr = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        ovf_exc;

  localparam logic [8:0] CTRL = 9'h000, STAT = 9'h004, DATA = 9'h100;

  branch_trace_buf i_branch_trace_buf (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= reg_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk(0, "R11 unexpected read", reg_rdata, 32'd0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(reg_rdata === e, t, reg_rdata, e);
      end
    end
  end

  function automatic logic [31:0] sa(input int i); return 32'h1000 + i * 16; endfunction
  function automatic logic [31:0] da(input int i); return 32'h8000 + i * 16; endfunction

  task automatic rd(input logic [8:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic ev(input logic [31:0] s, input logic [31:0] d, input bit hw, input logic [3:0] lvl);
    @(negedge clk);
    ev_src = s; ev_dst = d; ev_hwloop = hw; ev_level = lvl; ev_valid = 1;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic rd_ev(input logic [31:0] e, input string t, input logic [31:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_addr = DATA; reg_rd = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    ev_src = s; ev_dst = d; ev_hwloop = 0; ev_level = 4'd8; ev_valid = 1;
    @(negedge clk);
    reg_rd = 0; ev_valid = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd(CTRL, 0, "R9 reset ctrl");
    rd(STAT, 0, "R1 reset count");
    rd(DATA, 0, "R10 empty read");
    // power/enable gating
    ev(32'h10, 32'h20, 0, 4'd8);
    rd(STAT, 0, "R2 disabled");
    wr(CTRL, 32'h1);
    ev(32'h10, 32'h20, 0, 4'd8);
    rd(STAT, 0, "R2 power only");
    wr(CTRL, 32'h3);
    ev(32'h10, 32'h20, 1, 4'd8);
    rd(STAT, 0, "R3 hwloop");
    ev(32'h10, 32'h20, 0, 4'd1);
    rd(STAT, 0, "R3 reset level");
    ev(32'h100, 32'h200, 0, 4'd6);
    rd(STAT, 1, "R2 recorded");
    // ignored writes
    wr(STAT, 32'hFFFF_FFFF);
    wr(DATA, 32'hFFFF_FFFF);
    rd(CTRL, 3, "R9 ctrl unchanged");
    rd(STAT, 1, "R9 count unchanged");
    // read order
    rd(DATA, 32'h200, "R10 dst first");
    rd(STAT, 1, "R10 no pop on first");
    rd(DATA, 32'h100, "R10 src second");
    rd(STAT, 0, "R10 popped");
    // level filter with overflow-exception mode
    wr(CTRL, 32'h7);
    ev(32'h30, 32'h40, 0, 4'd3);
    rd(STAT, 0, "R4 level 3 dropped");
    ev(32'h30, 32'h40, 0, 4'd4);
    rd(STAT, 1, "R4 level 4 kept");
    rd(DATA, 32'h40, "R4 drain dst");
    rd(DATA, 32'h30, "R4 drain src");
    // fill and overflow exception
    for (int i = 1; i <= 16; i++) ev(sa(i), da(i), 0, 4'd8);
    rd(STAT, 16, "R1 full count");
    ev(sa(17), da(17), 0, 4'd8);
    chk(ovf_exc === 1'b1, "R5 ovf pulse", 32'(ovf_exc), 1);
    @(negedge clk);
    chk(ovf_exc === 1'b0, "R5 ovf one cycle", 32'(ovf_exc), 0);
    rd(STAT, 16, "R5 event discarded");
    // overwrite mode
    wr(CTRL, 32'h3);
    ev(sa(17), da(17), 0, 4'd8);
    chk(ovf_exc === 1'b0, "R6 no ovf", 32'(ovf_exc), 0);
    rd(STAT, 16, "R6 still full");
    for (int k = 17; k >= 2; k--) begin
      rd(DATA, da(k), "R6 drain dst");
      rd(DATA, sa(k), "R6 drain src");
    end
    rd(STAT, 0, "R6 oldest lost");
    // single-level compression
    wr(CTRL, 32'h0B);
    ev(32'h10, 32'h20, 0, 4'd8);
    ev(32'h10, 32'h20, 0, 4'd8);
    rd(STAT, 1, "R7 compressed");
    rd(DATA, 32'h21, "R7 dst marked");
    rd(DATA, 32'h10, "R7 src plain");
    ev(32'h10, 32'h20, 0, 4'd8);
    ev(32'h50, 32'h60, 0, 4'd8);
    ev(32'h10, 32'h20, 0, 4'd8);
    rd(STAT, 3, "R7 single ignores second-newest");
    for (int k = 0; k < 3; k++) begin
      rd(DATA, (k == 1) ? 32'h60 : 32'h20, "R7 drain dst");
      rd(DATA, (k == 1) ? 32'h50 : 32'h10, "R7 drain src");
    end
    // two-level compression
    wr(CTRL, 32'h13);
    ev(32'h10, 32'h20, 0, 4'd8);
    ev(32'h50, 32'h60, 0, 4'd8);
    ev(32'h10, 32'h20, 0, 4'd8);
    rd(STAT, 2, "R8 compressed");
    rd(DATA, 32'h60, "R8 newest dst");
    rd(DATA, 32'h50, "R8 newest src");
    rd(DATA, 32'h20, "R8 older dst");
    rd(DATA, 32'h11, "R8 older src marked");
    ev(32'h10, 32'h20, 0, 4'd8);
    ev(32'h10, 32'h20, 0, 4'd8);
    rd(DATA, 32'h21, "R8 single first");
    rd(DATA, 32'h10, "R8 single first src");
    // pop and event in same cycle
    wr(CTRL, 32'h0B);
    ev(32'h10, 32'h20, 0, 4'd8);
    ev(32'h50, 32'h60, 0, 4'd8);
    rd(DATA, 32'h60, "R12 first half");
    rd_ev(32'h50, "R12 pop value", 32'h10, 32'h20);
    rd(STAT, 1, "R12 event after pop");
    rd(DATA, 32'h21, "R12 compressed into survivor");
    rd(DATA, 32'h10, "R12 survivor src");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);
    finish_run();
  end
endmodule